// File: doc/BRIEF.md
# Microword-Steered 8-bit Arithmetic and Logic Unit

This unit is the datapath arithmetic and logic stage of a small 8-bit microcoded processor core. Fields of a decoded microword steer it every cycle. They pick the operation, the left (Q) and right (R) operands, whether the adder subtracts, and where the adder's carry-in comes from. For plain transfers, a field also picks which register value is passed through. The core's register file supplies the accumulator, both index registers, the stack pointer, the status word, the memory operand, the current carry flag and a one-hot or inverted one-hot bit mask.

The unit returns an 8-bit result together with carry-out, overflow, zero and sign bits. The surrounding flag logic can commit these to the status word. Besides add, subtract, increment, decrement, compare, logic ops, shifts and rotates, it covers three test-style operations on memory operands: a bit test, a test-and-clear and a test-and-set. It also covers single-bit set and clear of a memory byte through the mask operand. All outputs are registered once, with a synchronous active-high reset. Decimal arithmetic, register storage and sequencing belong to other blocks.

Top module: `alu8_core`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs become zero on that edge. Otherwise every output shows, one rising edge after the inputs are applied, the value computed from those inputs, and it holds until the next edge.
- R2: With operation code 0 and mask mode 0 or 3, the result depends on `xfr_sel`: 0 or 7 gives M, 1 gives A, 2 gives X, 3 gives Y, 4 gives zero, 5 gives S and 6 gives P.
- R3: Operation codes 1, 2 and 3 return A AND M, A OR M and A XOR M respectively.
- R4: Operation codes 4 (add), 5 (subtract), 6 (increment), 7 (decrement) and 15 (compare) all use one adder that computes Q + R' + ci. Q is A, M, X or Y for `q_sel` 0, 1, 2 or 3. R is 8'h01 when `r_one` is 1 and M otherwise. R' is ~R when `sub_mode` is 1 and R otherwise. ci is `sub_mode` when `cin_fixed` is 1 and `c_in` otherwise. `co` is the carry out of bit 7.
- R5: For the adder operations, `ovf` is the carry into bit 7 XOR the carry out of bit 7.
- R6: Code 8 returns R<<1 with `co`=R[7]. Code 9 returns R>>1 with a cleared MSB and `co`=R[0]. Code 10 returns {R[6:0],c_in} with `co`=R[7]. Code 11 returns {c_in,R[7:1]} with `co`=R[0].
- R7: Code 12 returns A AND M, with `nf`=M[7] and `ovf`=M[6]. Code 13 returns M AND NOT A. Code 14 returns M OR A. For codes 12 to 14, `zf` is 1 exactly when A AND M is zero.
- R8: With operation code 0, mask mode 1 returns M AND mask, and mask mode 2 returns M OR mask. Mask mode 3 acts as a plain transfer, and the mask mode has no effect on any other operation code.
- R9: Outside codes 12 to 14, `zf` is 1 exactly when the result is zero. Outside code 12, `nf` equals result bit 7. `ovf` is 0 for codes other than the adder codes and 12. `co` equals `c_in` for codes 0 to 3 and 12 to 14.
- R10: Compare (code 15, `sub_mode`=1, `cin_fixed`=1) sets `co` exactly when Q >= R unsigned, and `zf` exactly when Q equals R.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| op | input | 4 | Operation code |
| q_sel | input | 2 | Left adder operand select (A, M, X, Y) |
| r_one | input | 1 | Right operand is constant one when 1, else M |
| sub_mode | input | 1 | Adder subtracts (complements R) when 1 |
| cin_fixed | input | 1 | Carry-in taken from `sub_mode` when 1, else from `c_in` |
| xfr_sel | input | 3 | Transfer source select |
| mask_mode | input | 2 | Single-bit mode for transfers: 1 clear, 2 set |
| reg_a | input | 8 | Accumulator |
| reg_x | input | 8 | X index register |
| reg_y | input | 8 | Y index register |
| reg_s | input | 8 | Stack pointer |
| reg_p | input | 8 | Status word |
| mem | input | 8 | Memory operand M |
| bit_mask | input | 8 | Single-bit mask operand |
| c_in | input | 1 | Current carry flag |
| res | output | 8 | Registered result |
| co | output | 1 | Registered carry-out |
| ovf | output | 1 | Registered overflow |
| zf | output | 1 | Registered zero indication |
| nf | output | 1 | Registered sign indication |

## Verification
Every result and flag appears exactly one rising edge after its operands and control fields are applied. The bench drives on a falling edge, lets one rising edge pass, and samples on the next falling edge. It also checks that the outputs still hold the previous value just before that rising edge. Reset takes effect on the same edge, so the reset checks sample on the falling edge right after the edge where `rst` was high. This is done once at start-up and once in the middle of a run with nonzero operands present.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

  typedef enum logic [3:0] {
    OP_XFR  = 4'd0,  OP_AND  = 4'd1,  OP_OR   = 4'd2,  OP_XOR  = 4'd3,
    OP_ADD  = 4'd4,  OP_SUB  = 4'd5,  OP_INC  = 4'd6,  OP_DEC  = 4'd7,
    OP_SHL  = 4'd8,  OP_SHR  = 4'd9,  OP_ROL  = 4'd10, OP_ROR  = 4'd11,
    OP_BTST = 4'd12, OP_BCLR = 4'd13, OP_BSET = 4'd14, OP_CMP  = 4'd15
  } alu_op_e;

  typedef enum logic [2:0] {
    SRC_DFLT = 3'd0, SRC_A = 3'd1, SRC_X = 3'd2, SRC_Y = 3'd3,
    SRC_ZERO = 3'd4, SRC_S = 3'd5, SRC_P = 3'd6, SRC_MEM = 3'd7
  } xfr_src_e;

  typedef enum logic [1:0] {
    MSK_NONE = 2'd0, MSK_CLR = 2'd1, MSK_SET = 2'd2, MSK_RSVD = 2'd3
  } mask_op_e;

  function automatic logic uses_adder(alu_op_e o);
    return (o inside {OP_ADD, OP_SUB, OP_INC, OP_DEC, OP_CMP});
  endfunction

  function automatic logic uses_shifter(alu_op_e o);
    return (o inside {OP_SHL, OP_SHR, OP_ROL, OP_ROR});
  endfunction

  function automatic logic zero_from_and(alu_op_e o);
    return (o inside {OP_BTST, OP_BCLR, OP_BSET});
  endfunction

endpackage

// File: rtl/alu8_opsel.sv
module alu8_opsel #(
  parameter int W = 8
) (
  input  logic [1:0]   q_sel,
  input  logic         r_one,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_x,
  input  logic [W-1:0] reg_y,
  input  logic [W-1:0] mem,
  output logic [W-1:0] q_opnd,
  output logic [W-1:0] r_opnd
);
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  always_comb begin
    unique case (q_sel)
      2'd0: q_opnd = reg_a;
      2'd1: q_opnd = mem;
      2'd2: q_opnd = reg_x;
      default: q_opnd = reg_y;
    endcase
  end

  assign r_opnd = r_one ? ONE : mem;
endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] q_opnd,
  input  logic [W-1:0] r_opnd,
  input  logic         sub_mode,
  input  logic         carry_in,
  output logic [W-1:0] sum,
  output logic         carry_out,
  output logic         ovf
);
  localparam int LW = W - 1;

  logic [W-1:0] r_eff;
  logic [LW:0]  low;
  logic [1:0]   high;
  logic         c_into_msb;

  assign r_eff = sub_mode ? ~r_opnd : r_opnd;

  // Split the sum so the carry into the sign bit is visible for overflow.
  assign low        = {1'b0, q_opnd[LW-1:0]} + {1'b0, r_eff[LW-1:0]} + {{LW{1'b0}}, carry_in};
  assign c_into_msb = low[LW];
  assign high       = {1'b0, q_opnd[W-1]} + {1'b0, r_eff[W-1]} + {1'b0, c_into_msb};

  assign sum       = {high[0], low[LW-1:0]};
  assign carry_out = high[1];
  assign ovf       = c_into_msb ^ high[1];
endmodule

// File: rtl/alu8_misc.sv
module alu8_misc
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [2:0]   xfr_sel,
  input  logic [1:0]   mask_mode,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_x,
  input  logic [W-1:0] reg_y,
  input  logic [W-1:0] reg_s,
  input  logic [W-1:0] reg_p,
  input  logic [W-1:0] mem,
  input  logic [W-1:0] bit_mask,
  input  logic [W-1:0] r_opnd,
  input  logic         c_in,
  output logic [W-1:0] out,
  output logic         shift_co
);
  logic [W-1:0] xfr_val;

  always_comb begin
    unique case (xfr_src_e'(xfr_sel))
      SRC_A:    xfr_val = reg_a;
      SRC_X:    xfr_val = reg_x;
      SRC_Y:    xfr_val = reg_y;
      SRC_ZERO: xfr_val = '0;
      SRC_S:    xfr_val = reg_s;
      SRC_P:    xfr_val = reg_p;
      default:  xfr_val = mem;
    endcase
  end

  always_comb begin
    out      = '0;
    shift_co = c_in;
    unique case (op)
      OP_XFR: begin
        unique case (mask_op_e'(mask_mode))
          MSK_CLR: out = mem & bit_mask;
          MSK_SET: out = mem | bit_mask;
          default: out = xfr_val;
        endcase
      end
      OP_AND:  out = reg_a & mem;
      OP_OR:   out = reg_a | mem;
      OP_XOR:  out = reg_a ^ mem;
      OP_SHL:  begin out = {r_opnd[W-2:0], 1'b0}; shift_co = r_opnd[W-1]; end
      OP_SHR:  begin out = {1'b0, r_opnd[W-1:1]}; shift_co = r_opnd[0];   end
      OP_ROL:  begin out = {r_opnd[W-2:0], c_in}; shift_co = r_opnd[W-1]; end
      OP_ROR:  begin out = {c_in, r_opnd[W-1:1]}; shift_co = r_opnd[0];   end
      OP_BTST: out = reg_a & mem;
      OP_BCLR: out = mem & ~reg_a;
      OP_BSET: out = mem | reg_a;
      default: out = '0;
    endcase
  end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   op,
  input  logic [1:0]   q_sel,
  input  logic         r_one,
  input  logic         sub_mode,
  input  logic         cin_fixed,
  input  logic [2:0]   xfr_sel,
  input  logic [1:0]   mask_mode,
  input  logic [W-1:0] reg_a,
  input  logic [W-1:0] reg_x,
  input  logic [W-1:0] reg_y,
  input  logic [W-1:0] reg_s,
  input  logic [W-1:0] reg_p,
  input  logic [W-1:0] mem,
  input  logic [W-1:0] bit_mask,
  input  logic         c_in,
  output logic [W-1:0] res,
  output logic         co,
  output logic         ovf,
  output logic         zf,
  output logic         nf
);
  alu_op_e      op_e;
  logic [W-1:0] q_opnd, r_opnd, sum, misc_out, res_n;
  logic         add_ci, add_co, add_ov, shift_co;
  logic         co_n, ov_n, zf_n, nf_n;

  assign op_e   = alu_op_e'(op);
  assign add_ci = cin_fixed ? sub_mode : c_in;

  alu8_opsel #(.W(W)) u_opsel (
    .q_sel(q_sel), .r_one(r_one), .reg_a(reg_a), .reg_x(reg_x),
    .reg_y(reg_y), .mem(mem), .q_opnd(q_opnd), .r_opnd(r_opnd)
  );

  alu8_adder #(.W(W)) u_adder (
    .q_opnd(q_opnd), .r_opnd(r_opnd), .sub_mode(sub_mode), .carry_in(add_ci),
    .sum(sum), .carry_out(add_co), .ovf(add_ov)
  );

  alu8_misc #(.W(W)) u_misc (
    .op(op_e), .xfr_sel(xfr_sel), .mask_mode(mask_mode), .reg_a(reg_a),
    .reg_x(reg_x), .reg_y(reg_y), .reg_s(reg_s), .reg_p(reg_p), .mem(mem),
    .bit_mask(bit_mask), .r_opnd(r_opnd), .c_in(c_in),
    .out(misc_out), .shift_co(shift_co)
  );

  // Flag selection.
  always_comb begin
    res_n = uses_adder(op_e) ? sum : misc_out;
    if (uses_adder(op_e))        co_n = add_co;
    else if (uses_shifter(op_e)) co_n = shift_co;
    else                         co_n = c_in;
    if (uses_adder(op_e))        ov_n = add_ov;
    else if (op_e == OP_BTST)    ov_n = mem[W-2];
    else                         ov_n = 1'b0;
    zf_n = zero_from_and(op_e) ? ~|(reg_a & mem) : ~|res_n;
    nf_n = (op_e == OP_BTST) ? mem[W-1] : res_n[W-1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res <= '0;
      co  <= 1'b0;
      ovf <= 1'b0;
      zf  <= 1'b0;
      nf  <= 1'b0;
    end else begin
      res <= res_n;
      co  <= co_n;
      ovf <= ov_n;
      zf  <= zf_n;
      nf  <= nf_n;
    end
  end

  // Reset clears every output on the following edge (R1).
  assert_reset_clear_R1: assert property (@(posedge clk)
    rst |=> (res == '0 && !co && !ovf && !zf && !nf));

  // Logical shift right always leaves a zero sign bit (R6).
  assert_shr_msb_R6: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd9) |=> (res[W-1] == 1'b0 && nf == 1'b0));

  // Bit test reports the memory operand's two top bits (R7).
  assert_bit_flags_R7: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd12) |=> (nf == $past(mem[W-1]) && ovf == $past(mem[W-2])));

  // Single-bit set leaves every mask bit set in the result (R8).
  assert_mask_set_R8: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd0 && mask_mode == 2'd2) |=> ((res & $past(bit_mask)) == $past(bit_mask)));

  // Zero indication follows the result outside the test-style ops (R9).
  assert_zero_track_R9: assert property (@(posedge clk) disable iff (rst)
    !(op inside {4'd12, 4'd13, 4'd14}) |=> (zf == (res == '0)));

  // Compare on the accumulator: carry means A >= M unsigned (R10).
  assert_cmp_carry_R10: assert property (@(posedge clk) disable iff (rst)
    (op == 4'd15 && q_sel == 2'd0 && !r_one && sub_mode && cin_fixed)
      |=> (co == ($past(reg_a) >= $past(mem))));
endmodule

// File: tb/alu8_core_test.sv
module alu8_core_test;
  localparam int W  = 8;
  localparam int NV = 33;
  localparam logic [W-1:0] RA = 8'hC3, RX = 8'h12, RY = 8'h80, RS = 8'hFD, RP = 8'h24;

  typedef struct packed {
    logic [3:0] op;
    logic [1:0] qs;
    logic       rs;
    logic       sb;
    logic       cs;
    logic [2:0] os;
    logic [1:0] bo;
    logic       ci;
    logic [7:0] m;
    logic [7:0] mk;
    logic [7:0] er;
    logic       eco;
    logic       eov;
    logic       ez;
    logic       en;
    logic [3:0] rq;
  } vec_t;

  // Fixed registers: A=C3 X=12 Y=80 S=FD P=24.
  localparam vec_t VT [NV] = '{
    // R2 transfers
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h7E, 8'h00, 8'h7E, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd0, 1'b1, 8'h00, 8'h00, 8'hC3, 1'b1, 1'b0, 1'b0, 1'b1, 4'd2},
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd2, 2'd0, 1'b0, 8'h00, 8'h00, 8'h12, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd3, 2'd0, 1'b0, 8'h00, 8'h00, 8'h80, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd4, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd2},
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd5, 2'd0, 1'b0, 8'h00, 8'h00, 8'hFD, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd6, 2'd0, 1'b0, 8'h00, 8'h00, 8'h24, 1'b0, 1'b0, 1'b0, 1'b0, 4'd2},
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd7, 2'd0, 1'b0, 8'h81, 8'h00, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 4'd2},
    // R3 logic
    '{4'd1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h0F, 8'h00, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 4'd3},
    '{4'd2, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h0C, 8'h00, 8'hCF, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},
    '{4'd3, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'hC3, 8'h00, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 4'd3},
    // R4 / R5 adder
    '{4'd4, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h3C, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},
    '{4'd4, 2'd2, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h7F, 8'h00, 8'h91, 1'b0, 1'b1, 1'b0, 1'b1, 4'd5},
    '{4'd5, 2'd0, 1'b0, 1'b1, 1'b0, 3'd0, 2'd0, 1'b1, 8'h44, 8'h00, 8'h7F, 1'b1, 1'b1, 1'b0, 1'b0, 4'd5},
    '{4'd6, 2'd3, 1'b1, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},
    '{4'd7, 2'd1, 1'b1, 1'b1, 1'b1, 3'd0, 2'd0, 1'b0, 8'h00, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4},
    '{4'd6, 2'd1, 1'b1, 1'b0, 1'b1, 3'd0, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 4'd4},
    // R6 shifts
    '{4'd8, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h81, 8'h00, 8'h02, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
    '{4'd9, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h81, 8'h00, 8'h40, 1'b1, 1'b0, 1'b0, 1'b0, 4'd6},
    '{4'd10,2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h40, 8'h00, 8'h81, 1'b0, 1'b0, 1'b0, 1'b1, 4'd6},
    '{4'd11,2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h01, 8'h00, 8'h80, 1'b1, 1'b0, 1'b0, 1'b1, 4'd6},
    '{4'd11,2'd0, 1'b1, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'h55, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 4'd6},
    // R7 test-style ops
    '{4'd12,2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h3C, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 4'd7},
    '{4'd12,2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'hC0, 8'h00, 8'hC0, 1'b0, 1'b1, 1'b0, 1'b1, 4'd7},
    '{4'd13,2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b0, 8'hFF, 8'h00, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 4'd7},
    '{4'd14,2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd0, 1'b1, 8'h14, 8'h00, 8'hD7, 1'b1, 1'b0, 1'b1, 1'b1, 4'd7},
    // R10 compare
    '{4'd15,2'd0, 1'b0, 1'b1, 1'b1, 3'd0, 2'd0, 1'b0, 8'hC3, 8'h00, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 4'd10},
    '{4'd15,2'd3, 1'b0, 1'b1, 1'b1, 3'd0, 2'd0, 1'b0, 8'h81, 8'h00, 8'hFF, 1'b0, 1'b0, 1'b0, 1'b1, 4'd10},
    // R8 mask operations
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 1'b0, 8'hFF, 8'hFB, 8'hFB, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd2, 1'b0, 8'h00, 8'h40, 8'h40, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
    '{4'd0, 2'd0, 1'b0, 1'b0, 1'b0, 3'd1, 2'd3, 1'b0, 8'h00, 8'hFF, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b1, 4'd8},
    '{4'd1, 2'd0, 1'b0, 1'b0, 1'b0, 3'd0, 2'd1, 1'b0, 8'h0F, 8'h00, 8'h03, 1'b0, 1'b0, 1'b0, 1'b0, 4'd8},
    // R4 fixed carry-in ignores c_in
    '{4'd4, 2'd0, 1'b0, 1'b0, 1'b1, 3'd0, 2'd0, 1'b1, 8'h01, 8'h00, 8'hC4, 1'b0, 1'b0, 1'b0, 1'b1, 4'd4}
  };

  logic clk = 1'b0, rst = 1'b1;
  logic [3:0] op = '0;
  logic [1:0] q_sel = '0, mask_mode = '0;
  logic r_one = 1'b0, sub_mode = 1'b0, cin_fixed = 1'b0, c_in = 1'b0;
  logic [2:0] xfr_sel = '0;
  logic [W-1:0] mem = '0, bit_mask = '0;
  logic [W-1:0] res;
  logic co, ovf, zf, nf;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  alu8_core #(.W(W)) uut (
    .clk(clk), .rst(rst), .op(op), .q_sel(q_sel), .r_one(r_one),
    .sub_mode(sub_mode), .cin_fixed(cin_fixed), .xfr_sel(xfr_sel),
    .mask_mode(mask_mode), .reg_a(RA), .reg_x(RX), .reg_y(RY), .reg_s(RS),
    .reg_p(RP), .mem(mem), .bit_mask(bit_mask), .c_in(c_in),
    .res(res), .co(co), .ovf(ovf), .zf(zf), .nf(nf)
  );

  task automatic check(input string tag, input logic [11:0] got, input logic [11:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got res=%h co=%b ov=%b z=%b n=%b exp res=%h co=%b ov=%b z=%b n=%b",
               tag, got[11:4], got[3], got[2], got[1], got[0],
               exp[11:4], exp[3], exp[2], exp[1], exp[0]);
    end
  endtask

  task automatic drive(input vec_t v);
    op = v.op; q_sel = v.qs; r_one = v.rs; sub_mode = v.sb; cin_fixed = v.cs;
    xfr_sel = v.os; mask_mode = v.bo; c_in = v.ci; mem = v.m; bit_mask = v.mk;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state with nonzero operands present.
    mem = 8'hFF; op = 4'd2; c_in = 1'b1;
    @(negedge clk); @(negedge clk);
    check("R1 reset state", {res, co, ovf, zf, nf}, 12'h000);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VT[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VT[i].rq, i), {res, co, ovf, zf, nf},
            {VT[i].er, VT[i].eco, VT[i].eov, VT[i].ez, VT[i].en});
    end

    // R1: output holds until the next rising edge (previous vector gave C4,n=1).
    @(negedge clk);
    drive(VT[4]);
    #1;
    check("R1 hold before edge", {res, co, ovf, zf, nf}, {8'hC4, 4'b0001});
    @(negedge clk);
    check("R1 update after edge", {res, co, ovf, zf, nf}, {8'h00, 4'b0010});

    // R1: mid-run reset overrides a nonzero computation.
    @(negedge clk);
    drive(VT[1]);
    rst = 1'b1;
    @(negedge clk);
    check("R1 mid-run reset", {res, co, ovf, zf, nf}, 12'h000);
    rst = 1'b0;
    @(negedge clk);
    check("R2 after reset release", {res, co, ovf, zf, nf}, {8'hC3, 4'b1001});

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule